// File: doc/BRIEF.md
# Segmented Boundary Scan Register

This block holds the boundary scan cells of a two-lane, nine-bit-per-lane bidirectional transceiver. It has two kinds of cell. Observe cells sit on every system input: the pin values, the two direction pins and the two active-low enable pins. Drive cells sit on every system output and on the four internal output enables, one A-side and one B-side enable per lane. Drive cells carry an update latch whose value can stand in for the system value. An enable latch holding 1 turns on its side's outputs. The TAP controller and the instruction decoder sit outside this block. They supply one-cycle capture, shift and update strobes on the test clock, together with a two-bit chain select.

The chain select picks which cells form the serial path. The full chain is 80 cells long. The observe-only chain is 40 cells long. The drive-only chain is also 40 cells long. Cells that are not on the selected path keep their contents. Data moves toward the serial output from the lowest-numbered cell of the active path. New data enters at its highest-numbered cell. The parallel outputs are the update latches. An instruction decoder outside the block muxes them onto the pads when a test instruction is active.

Top module: `bscan_seg_register`

## Requirements
- R1: On a synchronous active-low reset, every shift stage and every update latch is cleared to 0, so all four internal enables are inactive and scan_out is 0.
- R2: Full-chain cell positions (LANE_W = 9, N = 80; lane l is 0 or 1, pin p is 0..8, and port bit l*9+p is lane l pin p). Cell 79-4l holds the lane-l direction pin, cell 78-4l the lane-l enable pin, cell 77-4l the lane-l A enable and cell 76-4l the lane-l B enable. Each data group g (0..7) covers cells 71-9g-p, in this order: A pin in lane 0, A pin in lane 1, B out lane 0, B out lane 1, B pin in lane 0, B pin in lane 1, A out lane 0, A out lane 1. A capture strobe loads each active cell from its parallel input. "Out" cells take the core's output value. Enable cells take the core's enables.
- R3: In the full chain (chain_sel 0), scan_out shows cell 0. A shift strobe moves each cell's content one position toward cell 0, and scan_in enters cell 79.
- R4: With chain_sel 1, only observe cells (those not listed as out or enable cells in R2) capture and shift. They form a 40-cell path that runs in descending cell order, from scan_in at cell 79 down to scan_out at cell 18.
- R5: With chain_sel 2, only drive cells capture and shift. They form a 40-cell path that runs from scan_in at cell 77 down to scan_out at cell 0.
- R6: Cells outside the selected path hold their value through capture and shift strobes. With no capture or shift strobe, scan_out does not change.
- R7: An update strobe copies every drive cell's shift stage into its latch when chain_sel is not 1. With chain_sel 1 an update strobe leaves the latches unchanged. The latches do not move without an update strobe.
- R8: When capture and shift are strobed in the same cycle, capture wins.
- R9: chain_sel 3 behaves exactly like chain_sel 0.
- R10: The latch of cell c appears at the parallel output named for that cell in R2: oe_a_upd, oe_b_upd, a_upd or b_upd, at bit l*9+p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| upd_dr | input | 1 | Update strobe |
| chain_sel | input | 2 | 0/3 full chain, 1 observe-only, 2 drive-only |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out (tail cell of the active path) |
| dir_pin | input | 2 | Direction pin per lane |
| oe_pin_n | input | 2 | Active-low enable pin per lane |
| a_pin | input | 2*LANE_W | A-side pin values |
| b_pin | input | 2*LANE_W | B-side pin values |
| a_core | input | 2*LANE_W | Core value bound for the A outputs |
| b_core | input | 2*LANE_W | Core value bound for the B outputs |
| oe_a_core | input | 2 | Core A-side enable per lane |
| oe_b_core | input | 2 | Core B-side enable per lane |
| a_upd | output | 2*LANE_W | Update latches of the A output cells |
| b_upd | output | 2*LANE_W | Update latches of the B output cells |
| oe_a_upd | output | 2 | Update latches of the A enable cells |
| oe_b_upd | output | 2 | Update latches of the B enable cells |

## Verification
Every strobe takes effect on the rising clock edge where it is sampled. Because scan_out is decoded straight from the tail stage, a captured or shifted bit is visible at scan_out one edge after the strobe. The latch outputs also change exactly one edge after an update strobe. The driver applies each strobe on a falling edge and queues the expected scan_out bit and latch word, stamped with the index of the next rising edge. The monitor compares those items 2 ns after that edge, so each result is read in the single cycle where it is first due and before the next stimulus.

// File: rtl/bscan_seg_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the segmented boundary scan register.
// Assumes two lanes, eight control-region cells and eight data groups of LANE_W cells.
package bscan_seg_pkg;

    typedef enum logic [1:0] {
        SEL_FULL     = 2'd0,
        SEL_INPUTS   = 2'd1,
        SEL_OUTPUTS  = 2'd2,
        SEL_FULL_ALT = 2'd3
    } chain_sel_e;

    localparam int CTL_CELLS   = 8;
    localparam int DATA_GROUPS = 8;

    // Control-region slots within one lane's four cells.
    localparam int SLOT_DIR  = 0;
    localparam int SLOT_PIN  = 1;
    localparam int SLOT_OE_A = 2;
    localparam int SLOT_OE_B = 3;

    // Data groups from the top of the data region downward.
    localparam int GRP_A_PIN  = 0;
    localparam int GRP_B_CORE = 2;
    localparam int GRP_B_PIN  = 4;
    localparam int GRP_A_CORE = 6;

    function automatic int chain_len(input int w);
        return CTL_CELLS + DATA_GROUPS * w;
    endfunction

    function automatic int ctl_bit(input int w, input int lane, input int slot);
        return chain_len(w) - 1 - 4 * lane - slot;
    endfunction

    function automatic int data_bit(input int w, input int grp, input int p);
        return chain_len(w) - CTL_CELLS - 1 - grp * w - p;
    endfunction

    // True for observe-and-drive cells (outputs and internal enables).
    function automatic bit is_drive_cell(input int w, input int i);
        int n;
        int g;
        n = chain_len(w);
        if (i >= n - CTL_CELLS) begin
            return ((n - 1 - i) % 4) >= 2;
        end
        g = (n - CTL_CELLS - 1 - i) / w;
        return (g == 2) || (g == 3) || (g == 6) || (g == 7);
    endfunction

    // Nearest higher cell of the given kind; chain_len means scan_in.
    function automatic int upstream(input int w, input int i, input bit drive);
        for (int j = i + 1; j < chain_len(w); j++) begin
            if (is_drive_cell(w, j) == drive) return j;
        end
        return chain_len(w);
    endfunction

    // Lowest cell of the given kind: the serial tail of that segment.
    function automatic int tail_cell(input int w, input bit drive);
        for (int j = 0; j < chain_len(w); j++) begin
            if (is_drive_cell(w, j) == drive) return j;
        end
        return 0;
    endfunction

    // Number of drive cells below cell i.
    function automatic int drive_rank(input int w, input int i);
        int cnt;
        cnt = 0;
        for (int j = 0; j < i; j++) begin
            if (is_drive_cell(w, j)) cnt++;
        end
        return cnt;
    endfunction

    // Cell index of the k-th drive cell counted from cell 0.
    function automatic int drive_at(input int w, input int k);
        int cnt;
        cnt = 0;
        for (int j = 0; j < chain_len(w); j++) begin
            if (is_drive_cell(w, j)) begin
                if (cnt == k) return j;
                cnt++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/bscan_capture_map.sv
`timescale 1ns/1ps
// Packs the parallel system values into one capture word in chain cell order.
// Assumes the cell layout given by bscan_seg_pkg; purely combinational.
module bscan_capture_map
    import bscan_seg_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int N     = CTL_CELLS + DATA_GROUPS * LANE_W,
    localparam int DW    = 2 * LANE_W
) (
    input  logic [1:0]    dir_pin,
    input  logic [1:0]    oe_pin_n,
    input  logic [DW-1:0] a_pin,
    input  logic [DW-1:0] b_pin,
    input  logic [DW-1:0] a_core,
    input  logic [DW-1:0] b_core,
    input  logic [1:0]    oe_a_core,
    input  logic [1:0]    oe_b_core,
    output logic [N-1:0]  cap_vec
);

    for (genvar l = 0; l < 2; l++) begin : g_lane
        // Control region of this lane.
        assign cap_vec[ctl_bit(LANE_W, l, SLOT_DIR)]  = dir_pin[l];
        assign cap_vec[ctl_bit(LANE_W, l, SLOT_PIN)]  = oe_pin_n[l];
        assign cap_vec[ctl_bit(LANE_W, l, SLOT_OE_A)] = oe_a_core[l];
        assign cap_vec[ctl_bit(LANE_W, l, SLOT_OE_B)] = oe_b_core[l];
        for (genvar p = 0; p < LANE_W; p++) begin : g_pin
            // Data groups of this lane and pin.
            assign cap_vec[data_bit(LANE_W, GRP_A_PIN + l, p)]  = a_pin[l*LANE_W + p];
            assign cap_vec[data_bit(LANE_W, GRP_B_CORE + l, p)] = b_core[l*LANE_W + p];
            assign cap_vec[data_bit(LANE_W, GRP_B_PIN + l, p)]  = b_pin[l*LANE_W + p];
            assign cap_vec[data_bit(LANE_W, GRP_A_CORE + l, p)] = a_core[l*LANE_W + p];
        end
    end

endmodule

// File: rtl/bscan_cell_chain.sv
`timescale 1ns/1ps
// Shift stages of all cells, with per-cell serial source picked by chain select.
// Assumes strobes are one test-clock cycle wide; capture beats shift in one cycle.
// Cells outside the selected segment hold their value.
module bscan_cell_chain
    import bscan_seg_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int N     = CTL_CELLS + DATA_GROUPS * LANE_W,
    localparam int DRV_N = N / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_dr,
    input  logic             shift_dr,
    input  logic [1:0]       chain_sel,
    input  logic             scan_in,
    input  logic [N-1:0]     cap_vec,
    output logic [DRV_N-1:0] drv_shift,
    output logic             scan_out
);

    localparam int IN_TAIL  = tail_cell(LANE_W, 1'b0);
    localparam int OUT_TAIL = tail_cell(LANE_W, 1'b1);

    logic         sel_inputs;
    logic         sel_outputs;
    logic         sel_full;
    logic [N-1:0] shift_q;
    logic [N-1:0] link;   // link[k] is the content of the cell above cell k (scan_in for the top).

    assign sel_inputs  = (chain_sel == SEL_INPUTS);
    assign sel_outputs = (chain_sel == SEL_OUTPUTS);
    assign sel_full    = !sel_inputs && !sel_outputs;
    assign link        = {scan_in, shift_q[N-1:1]};

    for (genvar i = 0; i < N; i++) begin : g_cell
        localparam bit DRV  = is_drive_cell(LANE_W, i);
        localparam int UP_K = upstream(LANE_W, i, DRV);
        logic member;
        logic stage_q;

        assign member = sel_full || (DRV ? sel_outputs : sel_inputs);

        // Capture, then shift, for cells on the selected path.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= 1'b0;
            end else if (member && cap_dr) begin
                stage_q <= cap_vec[i];
            end else if (member && shift_dr) begin
                stage_q <= sel_full ? link[i] : link[UP_K-1];
            end
        end

        assign shift_q[i] = stage_q;
    end

    for (genvar k = 0; k < DRV_N; k++) begin : g_gather
        assign drv_shift[k] = shift_q[drive_at(LANE_W, k)];
    end

    // Serial output from the tail of the selected path.
    always_comb begin
        if (sel_inputs)       scan_out = shift_q[IN_TAIL];
        else if (sel_outputs) scan_out = shift_q[OUT_TAIL];
        else                  scan_out = shift_q[0];
    end

endmodule

// File: rtl/bscan_update_bank.sv
`timescale 1ns/1ps
// Update latches of the drive cells, packed in ascending drive-cell order.
// Assumes an update under the observe-only selection must be ignored.
module bscan_update_bank
    import bscan_seg_pkg::*;
#(
    parameter int DRV_N = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_dr,
    input  logic [1:0]       chain_sel,
    input  logic [DRV_N-1:0] drv_shift,
    output logic [DRV_N-1:0] drv_upd
);

    // Copy shift stages to latches on an update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_upd <= '0;
        end else if (upd_dr && (chain_sel != SEL_INPUTS)) begin
            drv_upd <= drv_shift;
        end
    end

endmodule

// File: rtl/bscan_seg_register.sv
`timescale 1ns/1ps
// Boundary scan register with full, observe-only and drive-only serial paths.
// Assumes strobes come from an external TAP controller on clk; latch outputs
// are muxed onto pads outside this block.
module bscan_seg_register
    import bscan_seg_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int N     = CTL_CELLS + DATA_GROUPS * LANE_W,
    localparam int DRV_N = N / 2,
    localparam int DW    = 2 * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_dr,
    input  logic          shift_dr,
    input  logic          upd_dr,
    input  logic [1:0]    chain_sel,
    input  logic          scan_in,
    output logic          scan_out,
    input  logic [1:0]    dir_pin,
    input  logic [1:0]    oe_pin_n,
    input  logic [DW-1:0] a_pin,
    input  logic [DW-1:0] b_pin,
    input  logic [DW-1:0] a_core,
    input  logic [DW-1:0] b_core,
    input  logic [1:0]    oe_a_core,
    input  logic [1:0]    oe_b_core,
    output logic [DW-1:0] a_upd,
    output logic [DW-1:0] b_upd,
    output logic [1:0]    oe_a_upd,
    output logic [1:0]    oe_b_upd
);

    logic [N-1:0]     cap_vec;
    logic [DRV_N-1:0] drv_shift;
    logic [DRV_N-1:0] drv_upd;

    bscan_capture_map #(.LANE_W(LANE_W)) map_i (
        .dir_pin   (dir_pin),
        .oe_pin_n  (oe_pin_n),
        .a_pin     (a_pin),
        .b_pin     (b_pin),
        .a_core    (a_core),
        .b_core    (b_core),
        .oe_a_core (oe_a_core),
        .oe_b_core (oe_b_core),
        .cap_vec   (cap_vec)
    );

    bscan_cell_chain #(.LANE_W(LANE_W)) chain_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_dr    (cap_dr),
        .shift_dr  (shift_dr),
        .chain_sel (chain_sel),
        .scan_in   (scan_in),
        .cap_vec   (cap_vec),
        .drv_shift (drv_shift),
        .scan_out  (scan_out)
    );

    bscan_update_bank #(.DRV_N(DRV_N)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_dr    (upd_dr),
        .chain_sel (chain_sel),
        .drv_shift (drv_shift),
        .drv_upd   (drv_upd)
    );

    for (genvar l = 0; l < 2; l++) begin : g_out_lane
        assign oe_a_upd[l] = drv_upd[drive_rank(LANE_W, ctl_bit(LANE_W, l, SLOT_OE_A))];
        assign oe_b_upd[l] = drv_upd[drive_rank(LANE_W, ctl_bit(LANE_W, l, SLOT_OE_B))];
        for (genvar p = 0; p < LANE_W; p++) begin : g_out_pin
            assign a_upd[l*LANE_W + p] = drv_upd[drive_rank(LANE_W, data_bit(LANE_W, GRP_A_CORE + l, p))];
            assign b_upd[l*LANE_W + p] = drv_upd[drive_rank(LANE_W, data_bit(LANE_W, GRP_B_CORE + l, p))];
        end
    end

endmodule

// File: rtl/bscan_seg_register_chk.sv
`timescale 1ns/1ps
// Port-level checker for bscan_seg_register, attached by bind.
module bscan_seg_register_chk #(
    parameter int LANE_W = 9,
    localparam int DW    = 2 * LANE_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cap_dr,
    input logic          shift_dr,
    input logic          upd_dr,
    input logic [1:0]    chain_sel,
    input logic          scan_out,
    input logic [DW-1:0] a_upd,
    input logic [DW-1:0] b_upd,
    input logic [1:0]    oe_a_upd,
    input logic [1:0]    oe_b_upd
);

    logic [2*DW+3:0] latches;
    assign latches = {oe_a_upd, oe_b_upd, a_upd, b_upd};

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latches == '0));

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_dr |=> $stable(latches));

    assert_observe_update_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_dr && chain_sel == 2'd1) |=> $stable(latches));

    assert_quiet_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_dr && !shift_dr) ##1 $stable(chain_sel) |-> $stable(scan_out));

endmodule

bind bscan_seg_register bscan_seg_register_chk #(.LANE_W(LANE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_dr    (cap_dr),
    .shift_dr  (shift_dr),
    .upd_dr    (upd_dr),
    .chain_sel (chain_sel),
    .scan_out  (scan_out),
    .a_upd     (a_upd),
    .b_upd     (b_upd),
    .oe_a_upd  (oe_a_upd),
    .oe_b_upd  (oe_b_upd)
);

// File: tb/bscan_seg_register_tb.sv
`timescale 1ns/1ps
module bscan_seg_register_tb_top;

    localparam int W = 9;
    localparam int N = 80;

    typedef struct {
        int          due;
        int          kind;   // 0 scan_out, 1 latch word
        logic [39:0] exp;
        string       req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0, scan_in = 1'b0;
    logic [1:0] chain_sel = 2'd0;
    logic [1:0] dir_pin = '0, oe_pin_n = '0, oe_a_core = '0, oe_b_core = '0;
    logic [17:0] a_pin = '0, b_pin = '0, a_core = '0, b_core = '0;
    logic scan_out;
    logic [17:0] a_upd, b_upd;
    logic [1:0] oe_a_upd, oe_b_upd;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    item_t sb[$];
    logic [N-1:0] m_sr = '0;
    logic [N-1:0] m_upd = '0;

    bscan_seg_register #(.LANE_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr),
        .chain_sel(chain_sel), .scan_in(scan_in), .scan_out(scan_out),
        .dir_pin(dir_pin), .oe_pin_n(oe_pin_n), .a_pin(a_pin), .b_pin(b_pin),
        .a_core(a_core), .b_core(b_core), .oe_a_core(oe_a_core), .oe_b_core(oe_b_core),
        .a_upd(a_upd), .b_upd(b_upd), .oe_a_upd(oe_a_upd), .oe_b_upd(oe_b_upd)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void check(string req, logic [39:0] got, logic [39:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endfunction

    // R2 cell kinds and positions.
    function automatic bit is_drive(int i);
        if (i >= 72) return ((79 - i) % 4) >= 2;
        return ((71 - i) / 9) inside {2, 3, 6, 7};
    endfunction

    function automatic bit active(int i, logic [1:0] sel);
        if (sel == 2'd1) return !is_drive(i);
        if (sel == 2'd2) return is_drive(i);
        return 1'b1;
    endfunction

    function automatic logic [N-1:0] cap_image();
        logic [N-1:0] v;
        for (int l = 0; l < 2; l++) begin
            v[79-4*l] = dir_pin[l];
            v[78-4*l] = oe_pin_n[l];
            v[77-4*l] = oe_a_core[l];
            v[76-4*l] = oe_b_core[l];
            for (int p = 0; p < 9; p++) begin
                v[71-9*(0+l)-p] = a_pin[l*9+p];
                v[71-9*(2+l)-p] = b_core[l*9+p];
                v[71-9*(4+l)-p] = b_pin[l*9+p];
                v[71-9*(6+l)-p] = a_core[l*9+p];
            end
        end
        return v;
    endfunction

    // R10 latch word {oe_a, oe_b, a, b}.
    function automatic logic [39:0] latch_word(logic [N-1:0] u);
        logic [1:0] oa, ob;
        logic [17:0] a, b;
        for (int l = 0; l < 2; l++) begin
            oa[l] = u[77-4*l];
            ob[l] = u[76-4*l];
            for (int p = 0; p < 9; p++) begin
                a[l*9+p] = u[71-9*(6+l)-p];
                b[l*9+p] = u[71-9*(2+l)-p];
            end
        end
        return {oa, ob, a, b};
    endfunction

    function automatic int tail(logic [1:0] sel);
        for (int i = 0; i < N; i++) if (active(i, sel)) return i;
        return 0;
    endfunction

    // Driver: apply one cycle of strobes and queue what is due after the edge.
    task automatic step(input bit cap, input bit sh, input bit upd, input logic [1:0] sel,
                        input logic si, input string req);
        logic [N-1:0] nxt;
        logic [N-1:0] cv;
        cap_dr = cap; shift_dr = sh; upd_dr = upd; chain_sel = sel; scan_in = si;
        cv = cap_image();
        nxt = m_sr;
        for (int i = 0; i < N; i++) begin
            if (active(i, sel)) begin
                if (cap) nxt[i] = cv[i];
                else if (sh) begin
                    logic src;
                    bit found;
                    src = si;
                    found = 1'b0;
                    for (int j = i + 1; j < N; j++) begin
                        if (!found && active(j, sel)) begin
                            src = m_sr[j];
                            found = 1'b1;
                        end
                    end
                    nxt[i] = src;
                end
            end
        end
        if (upd && sel != 2'd1)
            for (int i = 0; i < N; i++) if (is_drive(i)) m_upd[i] = m_sr[i];
        m_sr = nxt;
        sb.push_back('{due: cyc + 1, kind: 0, exp: {39'b0, m_sr[tail(sel)]}, req: req});
        sb.push_back('{due: cyc + 1, kind: 1, exp: latch_word(m_upd), req: req});
        @(negedge clk);
        cap_dr = 1'b0; shift_dr = 1'b0; upd_dr = 1'b0;
    endtask

    task automatic frame(input logic [1:0] sel, input int len, input string req);
        step(1'b1, 1'b0, 1'b0, sel, 1'b0, req);
        for (int k = 0; k < len; k++) step(1'b0, 1'b1, 1'b0, sel, logic'($urandom_range(1)), req);
    endtask

    task automatic new_stimulus();
        dir_pin = 2'($urandom); oe_pin_n = 2'($urandom);
        oe_a_core = 2'($urandom); oe_b_core = 2'($urandom);
        a_pin = 18'($urandom); b_pin = 18'($urandom);
        a_core = 18'($urandom); b_core = 18'($urandom);
    endtask

    // Monitor: compare queued items 2 ns after their due edge.
    always @(posedge clk) begin
        #2;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            if (it.kind == 0) check(it.req, {39'b0, scan_out}, it.exp);
            else check(it.req, {oe_a_upd, oe_b_upd, a_upd, b_upd}, it.exp);
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1", {39'b0, scan_out}, 40'b0);
        check("R1", {oe_a_upd, oe_b_upd, a_upd, b_upd}, 40'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 capture and R3 full shift, then R7/R10 update.
        new_stimulus();
        frame(2'd0, 80, "R2_R3");
        step(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, "R7_R10");
        // R8: capture wins over shift.
        new_stimulus();
        step(1'b1, 1'b1, 1'b0, 2'd0, 1'b1, "R8");
        step(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R8");

        // R4: observe-only path; R7 update ignored there.
        new_stimulus();
        frame(2'd1, 40, "R4");
        step(1'b0, 1'b0, 1'b1, 2'd1, 1'b0, "R7");
        // R6: drive cells untouched by the observe-only traffic.
        step(1'b0, 1'b0, 1'b1, 2'd2, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R6");

        // R5: drive-only path, then update to outputs.
        new_stimulus();
        frame(2'd2, 40, "R5");
        step(1'b0, 1'b0, 1'b1, 2'd2, 1'b0, "R5_R10");

        // R9: select code 3 acts as full chain.
        new_stimulus();
        frame(2'd3, 80, "R9");
        step(1'b0, 1'b0, 1'b1, 2'd3, 1'b0, "R9");
        @(negedge clk);

        // R1: reset again from a loaded state.
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", {39'b0, scan_out}, 40'b0);
        check("R1", {oe_a_upd, oe_b_upd, a_upd, b_upd}, 40'b0);
        rst_n = 1'b1;
        m_sr = '0;
        m_upd = '0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule